// File: doc/BRIEF.md
# Clock buffer power-management controller

This block is the digital control core of a clock generator with four differential output pairs and one single-ended reference output. It decides, every cycle, whether each differential pair toggles or is parked with both legs low. It also sets the state of the reference output, which can be high-impedance, driven low or running.

A pair runs only when four conditions hold together: the part has been powered up, the power-good/power-down input is high, the PLL reports lock, and that pair's enable pin and register bit both allow it. The pair's run state changes only while the source clock is low, so a stopped or restarted pair never emits a shortened true-leg pulse.

On the first high level of the power-good input, the block captures two board straps. One strap picks the management-bus slave address. The other is a tri-level strap, delivered as two decoded bits, that picks the spread-spectrum depth. Both captured values then stay fixed until reset, whatever the power-good input does afterwards.

Top module: `clkpm_ctrl`

## Requirements
- R1: Each pair has an active-low enable pin. With the part powered, PLL locked and the register bit at 1, pin value 0 makes both legs of that pair toggle, and pin value 1 holds both legs low.
- R2: A register enable bit of 0 holds both legs of its pair low, whatever the pin value.
- R3: While the power-good input is low, and before it has ever been high, every pair holds both legs low, whatever the pins and register bits say.
- R4: Out of reset and until the power-good input is first high, the reference is high-impedance: `ref_state` = 2'b00, `ref_oe` = 0, `ref_lvl` = 0.
- R5: After the first power-up, power-good low with `wol_en` = 0 drives the reference low (`ref_state` = 2'b01, `ref_oe` = 1, `ref_lvl` = 0). With `wol_en` = 1 the reference keeps running (`ref_state` = 2'b10, `ref_lvl` follows `ref_src`). While power-good is high the reference runs.
- R6: At the first power-good high, address strap 0 gives `smb_addr` = 7'b1101000 and strap 1 gives 7'b1101010. Before that capture, `smb_addr` reads 7'b1101000.
- R7: The spread strap (hi, mid) is decoded at the first power-good high into `ss_sel`: (1,0) gives 2'b10 (-0.5 %), (0,1) gives 2'b01 (-0.25 %), and (0,0) or the undefined (1,1) gives 2'b00 (off). Before capture, `ss_sel` is 2'b00, and it never reads 2'b11.
- R8: Once captured, `smb_addr` and `ss_sel` hold until reset. Later power-good edges and strap changes do not resample them.
- R9: While `pll_locked` is 0, every pair holds both legs low.
- R10: A pair's run state changes only in a cycle where `dif_src` is low. Every true-leg high pulse therefore lasts the full source high phase, and the true leg is low in the cycle after `dif_src` was low.
- R11: After a power-down, raising power-good again resumes the enabled pairs without a new strap capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_i | input | 1 | Power-good / power-down input, asynchronous, high = on |
| oe_pin_n | input | 4 | Per-pair active-low enable pins, asynchronous |
| oe_reg | input | 4 | Per-pair register enable bits, 1 = allowed |
| wol_en | input | 1 | Register bit that keeps the reference running in power-down |
| pll_locked | input | 1 | PLL lock flag |
| dif_src | input | 1 | Level of the source clock for the differential pairs |
| ref_src | input | 1 | Level of the source clock for the reference output |
| addr_strap | input | 1 | Address-select strap |
| ss_strap_hi | input | 1 | Spread strap, decoded high level |
| ss_strap_mid | input | 1 | Spread strap, decoded middle level |
| dif_t | output | 4 | True leg of each pair |
| dif_c | output | 4 | Complement leg of each pair |
| ref_oe | output | 1 | Reference driver enable, 0 = high-impedance |
| ref_lvl | output | 1 | Reference output level |
| ref_state | output | 2 | Reference state: 00 high-Z, 01 low, 10 running |
| smb_addr | output | 7 | Captured 7-bit slave address |
| ss_sel | output | 2 | Captured spread select: 00 off, 01 -0.25 %, 10 -0.5 % |

## Verification
The bench applies a second power-up with changed straps. A design that resamples the straps on every power-good edge would then report the new address and spread code. Each strap code, including the undefined (1,1) pair, is tried after its own reset, so a decoder that maps (1,1) to a spread depth shows up. The reference is checked in all three states: an implementation that drives low before the first power-up, or that ignores the wake bit in power-down, gives the wrong state or a silent reference. A separate pulse-length monitor watches every true-leg high pulse while enables, lock and power-good toggle at arbitrary phases, so gating that acts mid-pulse produces a short pulse and is reported.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [1:0] {
    REF_HIZ = 2'b00,
    REF_LOW = 2'b01,
    REF_RUN = 2'b10
  } ref_state_e;

  typedef enum logic [1:0] {
    SS_OFF  = 2'b00,
    SS_QTR  = 2'b01,
    SS_HALF = 2'b10
  } ss_sel_e;

  // Tri-level strap arrives as two decoded bits; the illegal pair maps to off.
  function automatic ss_sel_e ss_decode(input logic hi, input logic mid);
    ss_sel_e res;
    case ({hi, mid})
      2'b10:   res = SS_HALF;
      2'b01:   res = SS_QTR;
      default: res = SS_OFF;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/clkpm_strap_latch.sv
module clkpm_strap_latch
  import clkpm_pkg::*;
#(
  parameter int                ADDR_W  = 7,
  parameter logic [ADDR_W-1:0] ADDR_LO = 7'b1101000,
  parameter logic [ADDR_W-1:0] ADDR_HI = 7'b1101010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_s,
  input  logic              addr_strap,
  input  logic              ss_hi,
  input  logic              ss_mid,
  output logic              seen,
  output logic [ADDR_W-1:0] addr,
  output ss_sel_e           ss
);

  logic              seen_q, seen_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  ss_sel_e           ss_q, ss_d;
  logic              capture;

  // Capture once: the first cycle the synchronized power-good is seen high.
  assign capture = pg_s && !seen_q;

  always_comb begin
    seen_d = seen_q;
    addr_d = addr_q;
    ss_d   = ss_q;
    if (capture) begin
      seen_d = 1'b1;
      addr_d = addr_strap ? ADDR_HI : ADDR_LO;
      ss_d   = ss_decode(ss_hi, ss_mid);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      addr_q <= ADDR_LO;
      ss_q   <= SS_OFF;
    end else if (capture) begin
      seen_q <= seen_d;
      addr_q <= addr_d;
      ss_q   <= ss_d;
    end
  end

  assign seen = seen_q;
  assign addr = addr_q;
  assign ss   = ss_q;

endmodule

// File: rtl/clkpm_pair_gate.sv
module clkpm_pair_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic src_lvl,
  input  logic want_run,
  output logic dif_t,
  output logic dif_c
);

  logic run_q, run_nxt;
  logic upd_en;
  logic t_q, t_d, c_q, c_d;

  // Run state may only move while the source clock is low.
  assign upd_en  = !src_lvl;
  assign run_nxt = upd_en ? want_run : run_q;

  always_comb begin
    t_d = run_nxt & src_lvl;
    c_d = run_nxt & ~src_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (upd_en) begin
      run_q <= run_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      t_q <= t_d;
      c_q <= c_d;
    end
  end

  assign dif_t = t_q;
  assign dif_c = c_q;

endmodule

// File: rtl/clkpm_ref_ctrl.sv
module clkpm_ref_ctrl
  import clkpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seen,
  input  logic       pg_s,
  input  logic       wol_en,
  input  logic       ref_src,
  output ref_state_e state,
  output logic       oe,
  output logic       lvl
);

  ref_state_e st;
  logic       lvl_q, lvl_d;

  always_comb begin
    if (!seen) begin
      st = REF_HIZ;
    end else if (pg_s || wol_en) begin
      st = REF_RUN;
    end else begin
      st = REF_LOW;
    end
  end

  assign lvl_d = (st == REF_RUN) & ref_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign state = st;
  assign oe    = (st != REF_HIZ);
  assign lvl   = lvl_q;

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter int NUM_PAIRS   = 4,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwrgd_i,
  input  logic [NUM_PAIRS-1:0] oe_pin_n,
  input  logic [NUM_PAIRS-1:0] oe_reg,
  input  logic                 wol_en,
  input  logic                 pll_locked,
  input  logic                 dif_src,
  input  logic                 ref_src,
  input  logic                 addr_strap,
  input  logic                 ss_strap_hi,
  input  logic                 ss_strap_mid,
  output logic [NUM_PAIRS-1:0] dif_t,
  output logic [NUM_PAIRS-1:0] dif_c,
  output logic                 ref_oe,
  output logic                 ref_lvl,
  output logic [1:0]           ref_state,
  output logic [ADDR_W-1:0]    smb_addr,
  output logic [1:0]           ss_sel
);

  localparam int SYNC_W = NUM_PAIRS + 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [SYNC_W-1:0]    pins_s;
  logic                 pg_s;
  logic [NUM_PAIRS-1:0] oe_pin_n_s;

  clkpm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async ({pwrgd_i, oe_pin_n}),
    .q_sync  (pins_s)
  );
  assign pg_s       = pins_s[SYNC_W-1];
  assign oe_pin_n_s = pins_s[NUM_PAIRS-1:0];

  logic    seen;
  ss_sel_e ss_q;

  clkpm_strap_latch #(.ADDR_W(ADDR_W)) u_strap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pg_s       (pg_s),
    .addr_strap (addr_strap),
    .ss_hi      (ss_strap_hi),
    .ss_mid     (ss_strap_mid),
    .seen       (seen),
    .addr       (smb_addr),
    .ss         (ss_q)
  );
  assign ss_sel = ss_q;

  logic                 powered;
  logic [NUM_PAIRS-1:0] want_run;

  assign powered = seen && pg_s && pll_locked;

  genvar p;
  generate
    for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign want_run[p] = powered && oe_reg[p] && !oe_pin_n_s[p];

      clkpm_pair_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .src_lvl  (dif_src),
        .want_run (want_run[p]),
        .dif_t    (dif_t[p]),
        .dif_c    (dif_c[p])
      );
    end
  endgenerate

  ref_state_e ref_st;

  clkpm_ref_ctrl u_ref (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .seen    (seen),
    .pg_s    (pg_s),
    .wol_en  (wol_en),
    .ref_src (ref_src),
    .state   (ref_st),
    .oe      (ref_oe),
    .lvl     (ref_lvl)
  );
  assign ref_state = ref_st;

endmodule

// File: rtl/clkpm_ctrl_chk.sv
module clkpm_ctrl_chk #(
  parameter int NUM_PAIRS = 4,
  parameter int ADDR_W    = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dif_src,
  input logic [NUM_PAIRS-1:0] dif_t,
  input logic [NUM_PAIRS-1:0] dif_c,
  input logic                 ref_oe,
  input logic                 ref_lvl,
  input logic [1:0]           ref_state,
  input logic [ADDR_W-1:0]    smb_addr,
  input logic [1:0]           ss_sel
);

  // R4: high-impedance is left only once, never re-entered without reset
  p_hiz_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_state != 2'b00) |=> (ref_state != 2'b00));

  // R4: nothing is driven on the reference while high-impedance
  p_hiz_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_state == 2'b00) |-> (!ref_oe && !ref_lvl));

  // R3: pairs stay dark before the first power-up
  p_dark_before_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_state == 2'b00) |-> (dif_t == '0 && dif_c == '0));

  // R8: captured straps are frozen after power-up
  p_straps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_state != 2'b00) |=> ($stable(smb_addr) && $stable(ss_sel)));

  // R7: the spread select never carries the unused code
  p_ss_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_sel != 2'b11);

  genvar i;
  generate
    for (i = 0; i < NUM_PAIRS; i++) begin : g_chk
      // R10: a true-leg pulse is not cut while the source stays high
      p_no_runt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dif_t[i] && dif_src) |=> dif_t[i]);
      // R10: true leg is low after a low source cycle
      p_true_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dif_src |=> !dif_t[i]);
    end
  endgenerate

endmodule

bind clkpm_ctrl clkpm_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dif_src   (dif_src),
  .dif_t     (dif_t),
  .dif_c     (dif_c),
  .ref_oe    (ref_oe),
  .ref_lvl   (ref_lvl),
  .ref_state (ref_state),
  .smb_addr  (smb_addr),
  .ss_sel    (ss_sel)
);

// File: tb/sim_clkpm_ctrl.sv
module sim_clkpm_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwrgd_i;
  logic [3:0] oe_pin_n;
  logic [3:0] oe_reg;
  logic       wol_en;
  logic       pll_locked;
  logic       dif_src = 1'b0;
  logic       ref_src = 1'b0;
  logic       addr_strap;
  logic       ss_strap_hi;
  logic       ss_strap_mid;
  logic [3:0] dif_t;
  logic [3:0] dif_c;
  logic       ref_oe;
  logic       ref_lvl;
  logic [1:0] ref_state;
  logic [6:0] smb_addr;
  logic [1:0] ss_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  clkpm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pwrgd_i(pwrgd_i), .oe_pin_n(oe_pin_n),
    .oe_reg(oe_reg), .wol_en(wol_en), .pll_locked(pll_locked),
    .dif_src(dif_src), .ref_src(ref_src), .addr_strap(addr_strap),
    .ss_strap_hi(ss_strap_hi), .ss_strap_mid(ss_strap_mid),
    .dif_t(dif_t), .dif_c(dif_c), .ref_oe(ref_oe), .ref_lvl(ref_lvl),
    .ref_state(ref_state), .smb_addr(smb_addr), .ss_sel(ss_sel)
  );

  // Source clocks: dif_src has a 4-cycle period, ref_src a 2-cycle period.
  initial begin
    forever begin
      @(posedge clk); #2;
      ref_src = ~ref_src;
      @(posedge clk); #2;
      ref_src = ~ref_src;
      dif_src = ~dif_src;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    string      tag;
    logic [3:0] run_mask;
    logic [1:0] rstate;
    logic [6:0] addr;
    logic [1:0] ss;
  } exp_t;

  exp_t exp_q[$];
  event mon_done;

  // Monitor: pops one expected item, observes 8 cycles, compares.
  initial begin
    forever begin
      exp_t       e;
      logic [3:0] t_any, c_any, both;
      logic       ref_hi, oe_seen;
      logic [1:0] rs_seen;
      logic [6:0] a_seen;
      logic [1:0] s_seen;
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      t_any = '0; c_any = '0; both = '0; ref_hi = 1'b0;
      @(negedge clk);
      oe_seen = ref_oe; rs_seen = ref_state; a_seen = smb_addr; s_seen = ss_sel;
      for (int k = 0; k < 8; k++) begin
        if (k > 0) @(negedge clk);
        t_any  |= dif_t;
        c_any  |= dif_c;
        both   |= (dif_t & dif_c);
        ref_hi |= ref_lvl;
      end
      check({e.tag, " true legs"},  {28'd0, t_any}, {28'd0, e.run_mask});
      check({e.tag, " comp legs"},  {28'd0, c_any}, {28'd0, e.run_mask});
      check({e.tag, " legs overlap"}, {28'd0, both}, 32'd0);
      check({e.tag, " ref_state"},  {30'd0, rs_seen}, {30'd0, e.rstate});
      check({e.tag, " ref_oe"},     {31'd0, oe_seen}, {31'd0, (e.rstate != 2'b00)});
      check({e.tag, " ref toggles"}, {31'd0, ref_hi}, {31'd0, (e.rstate == 2'b10)});
      check({e.tag, " smb_addr"},   {25'd0, a_seen}, {25'd0, e.addr});
      check({e.tag, " ss_sel"},     {30'd0, s_seen}, {30'd0, e.ss});
      -> mon_done;
    end
  end

  // R10: every true-leg high pulse lasts two cycles (full source high phase).
  int pulse_len [4];
  initial begin
    for (int i = 0; i < 4; i++) pulse_len[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (!rst_n) begin
          pulse_len[i] = 0;
        end else if (dif_t[i]) begin
          pulse_len[i]++;
        end else if (pulse_len[i] != 0) begin
          check($sformatf("R10 pulse length pair %0d", i), pulse_len[i], 2);
          pulse_len[i] = 0;
        end
      end
    end
  end

  task automatic settle_and_expect(string tag, logic [3:0] mask, logic [1:0] rs,
                                   logic [6:0] addr, logic [1:0] ss);
    exp_t e;
    repeat (8) @(posedge clk);
    e.tag = tag; e.run_mask = mask; e.rstate = rs; e.addr = addr; e.ss = ss;
    exp_q.push_back(e);
    @(mon_done);
    @(posedge clk); #2;
  endtask

  task automatic do_reset(logic a, logic hi, logic mid);
    @(posedge clk); #2;
    rst_n = 1'b0; pwrgd_i = 1'b0;
    addr_strap = a; ss_strap_hi = hi; ss_strap_mid = mid;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
  endtask

  localparam logic [6:0] A_LO = 7'b1101000;
  localparam logic [6:0] A_HI = 7'b1101010;

  initial begin
    rst_n = 1'b0; pwrgd_i = 1'b0; oe_pin_n = 4'h0; oe_reg = 4'hF;
    wol_en = 1'b0; pll_locked = 1'b1;
    addr_strap = 1'b0; ss_strap_hi = 1'b0; ss_strap_mid = 1'b0;
    do_reset(1'b0, 1'b0, 1'b0);

    settle_and_expect("R4 R3 before power-up", 4'h0, 2'b00, A_LO, 2'b00);
    pwrgd_i = 1'b1;
    settle_and_expect("R1 R6 R7 first power-up", 4'hF, 2'b10, A_LO, 2'b00);
    oe_pin_n = 4'b0101;
    settle_and_expect("R1 pins disable pairs 0,2", 4'b1010, 2'b10, A_LO, 2'b00);
    oe_pin_n = 4'h0; oe_reg = 4'b0011;
    settle_and_expect("R2 register bits off", 4'b0011, 2'b10, A_LO, 2'b00);
    oe_reg = 4'hF; pll_locked = 1'b0;
    settle_and_expect("R9 PLL unlocked", 4'h0, 2'b10, A_LO, 2'b00);
    pll_locked = 1'b1;
    settle_and_expect("R9 PLL relocked", 4'hF, 2'b10, A_LO, 2'b00);
    pwrgd_i = 1'b0;
    settle_and_expect("R3 R5 power-down ref low", 4'h0, 2'b01, A_LO, 2'b00);
    wol_en = 1'b1;
    settle_and_expect("R5 wake keeps ref running", 4'h0, 2'b10, A_LO, 2'b00);
    wol_en = 1'b0;
    addr_strap = 1'b1; ss_strap_hi = 1'b1;
    pwrgd_i = 1'b1;
    settle_and_expect("R8 R11 re-power keeps straps", 4'hF, 2'b10, A_LO, 2'b00);

    do_reset(1'b1, 1'b1, 1'b0);
    settle_and_expect("R4 after reset", 4'h0, 2'b00, A_LO, 2'b00);
    pwrgd_i = 1'b1;
    settle_and_expect("R6 R7 high addr, half spread", 4'hF, 2'b10, A_HI, 2'b10);

    do_reset(1'b0, 1'b0, 1'b1);
    pwrgd_i = 1'b1;
    settle_and_expect("R7 quarter spread", 4'hF, 2'b10, A_LO, 2'b01);

    do_reset(1'b1, 1'b1, 1'b1);
    pwrgd_i = 1'b1;
    settle_and_expect("R7 undefined strap is off", 4'hF, 2'b10, A_HI, 2'b00);

    // R10 under enable churn at varied phases
    for (int k = 0; k < 12; k++) begin
      oe_pin_n = k[3:0];
      repeat (k % 3 + 1) @(posedge clk);
      #1;
    end
    oe_pin_n = 4'h0;
    settle_and_expect("R10 R1 after churn", 4'hF, 2'b10, A_HI, 2'b00);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule